// File: doc/BRIEF.md
# Configurable CRC and Checksum Engine

This engine reduces a stream of software writes to a running CRC or a 16-bit ones-complement sum. Software first programs a control register. The control register picks the algorithm, the starting value, the input width, per-byte bit reversal and halfword or byte swapping on the way in, and per-byte bit reversal and inversion on the way out. Software then writes each data item to the data register. The engine absorbs a full item in the cycle it is written, so back-to-back writes are all taken.

Two registers return results. The seed register loads a starting value and always shows the raw running state. The result register shows that state after the output steps chosen in the control register have been applied. All registers sit on one request channel with a one-cycle read response.

Top module: `crc_csum_engine`

## Requirements
- R1: After reset the control register and the seed register both read 0, and `rsp_valid` is low.
- R2: Every accepted read returns `rsp_valid` high with its data in the next cycle, and only then. Control reads show only the defined bits (mask 0x73BF). Reads of the data register and of unmapped offsets return 0. Byte offsets are: control 0x00, seed 0x10, data 0x14, result 0x18.
- R3: Kind field ctrl[3:0] selects the algorithm. 0 is poly 0x8005 at 16 bits, 1 is 0x1021 at 16 bits, 2 is 0x04C11DB7 at 32 bits, and 3 is 0x1EDC6F41 at 32 bits. All of them are unreflected and shift MSB first. In the 16-bit kinds, state bits [31:16] read 0 after a data write.
- R4: Kind 8 adds the state's low 16 bits to the item with end-around carry. A word adds its upper and lower halfwords, and a byte adds as a low byte. Bits [31:16] stay 0.
- R5: Start field ctrl[14:13] picks the starting value for a data write: 2'b10 means zero, 2'b11 means all ones, and any other code means the current state. Every data write clears the field to 2'b00.
- R6: When ctrl[12] is 1, only bits [7:0] of a data write are used, and the swap controls have no effect.
- R7: When ctrl[7] is 1, the bit order of every input byte is reversed before processing.
- R8: In word mode, ctrl[4] swaps the bytes within each halfword and ctrl[5] swaps the two halfwords.
- R9: When ctrl[8] is 1, the result register shows the state with the bit order of every byte reversed.
- R10: When ctrl[9] is 1, the result register inverts the active width: 16 bits for kinds 0, 1 and 8, and 32 bits otherwise.
- R11: A seed write loads the state with the full 32-bit word, and a seed read returns the raw state.
- R12: A data write with any other kind code leaves the state at its starting value.
- R13: `req_ready` is always high, and data writes on consecutive cycles are each absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |

## Verification
The hardest conditions to reach are combined ones. One is a start code that has to be taken on the first data write and dropped on the second, while the swap and reversal controls are changing. Another is a stream of back-to-back data writes with no idle cycle between them. The stimulus mixes random control words, random seeds and runs of 1 to 4 data writes. It adds directed runs: known check strings, a burst of writes on consecutive cycles, and an unassigned kind code. Each run reads the seed, result and control registers back against a bench model.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int W = 32;
  localparam logic [3:0] KIND_P16A = 4'd0;
  localparam logic [3:0] KIND_P16B = 4'd1;
  localparam logic [3:0] KIND_P32A = 4'd2;
  localparam logic [3:0] KIND_P32C = 4'd3;
  localparam logic [3:0] KIND_SUM  = 4'd8;
  localparam logic [31:0] CTRL_MASK = 32'h0000_73BF;

  typedef struct packed {
    logic [1:0] start;
    logic       byte_mode;
    logic [1:0] rsv_b;
    logic       out_inv;
    logic       out_rev;
    logic       in_rev;
    logic       rsv_a;
    logic [1:0] swap;
    logic [3:0] kind;
  } ctrl_t;

  function automatic logic [W-1:0] crc_run(input logic [W-1:0] st, input logic [W-1:0] d,
                                           input logic byte_m, input logic [W-1:0] poly,
                                           input logic wide);
    logic [W-1:0] r;
    logic fb;
    r = wide ? st : {16'h0, st[15:0]};
    for (int i = W - 1; i >= 0; i--) begin
      if (!byte_m || i < 8) begin
        fb = (wide ? r[W-1] : r[15]) ^ d[i];
        r  = r << 1;
        if (!wide) r[W-1:16] = '0;
        if (fb) r = r ^ poly;
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] sum_run(input logic [W-1:0] st, input logic [W-1:0] d,
                                           input logic byte_m);
    logic [17:0] acc;
    acc = {2'b0, st[15:0]};
    if (byte_m) acc = acc + {10'b0, d[7:0]};
    else        acc = acc + {2'b0, d[31:16]} + {2'b0, d[15:0]};
    acc = {2'b0, acc[15:0]} + {16'b0, acc[17:16]};
    acc = {2'b0, acc[15:0]} + {16'b0, acc[17:16]};
    return {16'h0, acc[15:0]};
  endfunction
endpackage

// File: rtl/crc_in_shape.sv
module crc_in_shape
  import crc_pkg::*;
#(
  parameter int NBYTES = W / 8
) (
  input  logic [W-1:0] din,
  input  logic         in_rev,
  input  logic [1:0]   swap,
  input  logic         byte_mode,
  output logic [W-1:0] dout
);
  logic [W-1:0] rev;
  logic [W-1:0] sw_b;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign rev[b*8+k] = in_rev ? din[b*8+7-k] : din[b*8+k];
    end
  end

  always_comb begin
    sw_b = swap[0] ? {rev[23:16], rev[31:24], rev[7:0], rev[15:8]} : rev;
    if (byte_mode)    dout = {24'h0, rev[7:0]};
    else if (swap[1]) dout = {sw_b[15:0], sw_b[31:16]};
    else              dout = sw_b;
  end
endmodule

// File: rtl/crc_step.sv
module crc_step
  import crc_pkg::*;
(
  input  logic [W-1:0] start,
  input  logic [W-1:0] word,
  input  logic         byte_mode,
  input  logic [3:0]   kind,
  output logic [W-1:0] next
);
  always_comb begin
    unique case (kind)
      KIND_P16A: next = crc_run(start, word, byte_mode, 32'h0000_8005, 1'b0);
      KIND_P16B: next = crc_run(start, word, byte_mode, 32'h0000_1021, 1'b0);
      KIND_P32A: next = crc_run(start, word, byte_mode, 32'h04C1_1DB7, 1'b1);
      KIND_P32C: next = crc_run(start, word, byte_mode, 32'h1EDC_6F41, 1'b1);
      KIND_SUM:  next = sum_run(start, word, byte_mode);
      default:   next = start;
    endcase
  end
endmodule

// File: rtl/crc_out_shape.sv
module crc_out_shape
  import crc_pkg::*;
#(
  parameter int NBYTES = W / 8
) (
  input  logic [W-1:0] state,
  input  logic [3:0]   kind,
  input  logic         out_rev,
  input  logic         out_inv,
  output logic [W-1:0] result
);
  logic [W-1:0] rev;
  logic         narrow;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign rev[b*8+k] = out_rev ? state[b*8+7-k] : state[b*8+k];
    end
  end

  assign narrow = (kind == KIND_P16A) || (kind == KIND_P16B) || (kind == KIND_SUM);

  always_comb begin
    result = rev;
    if (out_inv) result = rev ^ (narrow ? 32'h0000_FFFF : 32'hFFFF_FFFF);
  end
endmodule

// File: rtl/crc_csum_engine.sv
module crc_csum_engine
  import crc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_CTRL = 'h00,
  parameter int OFF_SEED = 'h10,
  parameter int OFF_DATA = 'h14,
  parameter int OFF_RSLT = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(OFF_SEED);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_RSLT = ADDR_W'(OFF_RSLT);

  ctrl_t        ctrl_q;
  logic [W-1:0] state_q;
  logic [W-1:0] start_v, shaped, next_v, result_v, rd_mux;
  logic         wr_ctrl, wr_seed, wr_data, rd_any;

  assign req_ready = 1'b1;
  assign wr_ctrl = req_valid && req_write && (req_addr == A_CTRL);
  assign wr_seed = req_valid && req_write && (req_addr == A_SEED);
  assign wr_data = req_valid && req_write && (req_addr == A_DATA);
  assign rd_any  = req_valid && !req_write;

  always_comb begin
    unique case (ctrl_q.start)
      2'b10:   start_v = '0;
      2'b11:   start_v = '1;
      default: start_v = state_q;
    endcase
  end

  crc_in_shape u_in (
    .din(req_wdata), .in_rev(ctrl_q.in_rev), .swap(ctrl_q.swap),
    .byte_mode(ctrl_q.byte_mode), .dout(shaped)
  );

  crc_step u_step (
    .start(start_v), .word(shaped), .byte_mode(ctrl_q.byte_mode),
    .kind(ctrl_q.kind), .next(next_v)
  );

  crc_out_shape u_out (
    .state(state_q), .kind(ctrl_q.kind), .out_rev(ctrl_q.out_rev),
    .out_inv(ctrl_q.out_inv), .result(result_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      state_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(req_wdata[14:0] & CTRL_MASK[14:0]);
      if (wr_seed) state_q <= req_wdata;
      if (wr_data) begin
        state_q      <= next_v;
        ctrl_q.start <= 2'b00;
      end
    end
  end

  always_comb begin
    if      (req_addr == A_CTRL) rd_mux = {17'h0, ctrl_q};
    else if (req_addr == A_SEED) rd_mux = state_q;
    else if (req_addr == A_RSLT) rd_mux = result_v;
    else                         rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_any;
      if (rd_any) rsp_rdata <= rd_mux;
    end
  end

  a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == A_DATA) |=> ctrl_q.start == 2'b00);
  a_r11_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == A_SEED) |=> state_q == $past(req_wdata));
  a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && (ctrl_q.kind == KIND_P16A || ctrl_q.kind == KIND_P16B
                 || ctrl_q.kind == KIND_SUM)) |=> state_q[31:16] == 16'h0);
  a_r12_unknown_kind_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && ctrl_q.start == 2'b00 && ctrl_q.kind[3:2] == 2'b01) |=> $stable(state_q));
  a_r13_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_ready);
endmodule

// File: tb/crc_csum_engine_bench.sv
module crc_csum_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] O_CTRL = 8'h00, O_SEED = 8'h10, O_DATA = 8'h14, O_RSLT = 8'h18;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic req_ready, rsp_valid;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0, rsp_rdata;
  int checks = 0, errors = 0;
  logic [31:0] m_ctrl = 0, m_state = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_csum_engine u_crc_csum_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] brev(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [31:0] m_in(input logic [31:0] c, input logic [31:0] d);
    logic [7:0] by [4];
    logic [7:0] t;
    for (int i = 0; i < 4; i++) by[i] = c[7] ? brev(d[i*8 +: 8]) : d[i*8 +: 8];
    if (c[12]) return {24'h0, by[0]};
    if (c[4]) begin
      t = by[0]; by[0] = by[1]; by[1] = t;
      t = by[2]; by[2] = by[3]; by[3] = t;
    end
    if (c[5]) begin
      t = by[0]; by[0] = by[2]; by[2] = t;
      t = by[1]; by[1] = by[3]; by[3] = t;
    end
    return {by[3], by[2], by[1], by[0]};
  endfunction

  function automatic logic [31:0] m_crc(input logic [31:0] s0, input logic [31:0] d,
                                        input int nb, input logic [31:0] poly, input int w);
    logic [31:0] s, msk;
    logic top;
    msk = (w == 16) ? 32'hFFFF : 32'hFFFF_FFFF;
    s = s0 & msk;
    for (int k = nb - 1; k >= 0; k--) begin
      top = s[w-1];
      s = (s << 1) & msk;
      if (top ^ d[k]) s = s ^ poly;
    end
    return s;
  endfunction

  function automatic logic [31:0] m_step(input logic [31:0] c, input logic [31:0] st,
                                         input logic [31:0] d);
    logic [31:0] s0, x;
    int nb, acc;
    s0 = (c[14:13] == 2'b10) ? 32'h0 : (c[14:13] == 2'b11) ? 32'hFFFF_FFFF : st;
    x = m_in(c, d);
    nb = c[12] ? 8 : 32;
    case (c[3:0])
      4'd0: return m_crc(s0, x, nb, 32'h8005, 16);
      4'd1: return m_crc(s0, x, nb, 32'h1021, 16);
      4'd2: return m_crc(s0, x, nb, 32'h04C11DB7, 32);
      4'd3: return m_crc(s0, x, nb, 32'h1EDC6F41, 32);
      4'd8: begin
        acc = int'(s0[15:0]) + (c[12] ? int'(x[7:0]) : int'(x[31:16]) + int'(x[15:0]));
        while (acc > 32'hFFFF) acc = (acc & 32'hFFFF) + (acc >> 16);
        return 32'(acc);
      end
      default: return s0;
    endcase
  endfunction

  function automatic logic [31:0] m_out(input logic [31:0] c, input logic [31:0] st);
    logic [31:0] r;
    r = st;
    if (c[8]) for (int i = 0; i < 4; i++) r[i*8 +: 8] = brev(st[i*8 +: 8]);
    if (c[9]) r = r ^ ((c[3:0] == 0 || c[3:0] == 1 || c[3:0] == 8) ? 32'hFFFF : 32'hFFFF_FFFF);
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
    if (a == O_CTRL) m_ctrl = d & 32'h73BF;
    if (a == O_SEED) m_state = d;
    if (a == O_DATA) begin
      m_state = m_step(m_ctrl, m_state, d);
      m_ctrl[14:13] = 2'b00;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk("R2 rsp_valid", {31'h0, rsp_valid}, 32'h1);
    d = rsp_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(O_SEED, v);   chk({tag, " seed"}, v, m_state);
    rd(O_RSLT, v);   chk({tag, " result"}, v, m_out(m_ctrl, m_state));
    rd(O_CTRL, v);   chk({tag, " ctrl"}, v, m_ctrl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [3:0] kinds [6];
    kinds = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd5};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rsp_valid at reset", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1;
    rd(O_CTRL, v); chk("R1 ctrl reset", v, 32'h0);
    rd(O_SEED, v); chk("R1 seed reset", v, 32'h0);
    chk("R13 ready", {31'h0, req_ready}, 32'h1);

    // R2: control mask and unmapped offsets
    wr(O_CTRL, 32'hFFFF_FFFF);
    rd(O_CTRL, v); chk("R2 ctrl mask", v, 32'h73BF);
    rd(8'h04, v);  chk("R2 unmapped", v, 32'h0);
    rd(O_DATA, v); chk("R2 data reads zero", v, 32'h0);

    // R3 R5 R6: known check strings, byte mode
    wr(O_CTRL, 32'h7002);
    for (int i = 0; i < 9; i++) begin
      wr(O_DATA, 32'hABCDEF00 | (32'h31 + i));
      if (i == 0) begin rd(O_CTRL, v); chk("R5 start cleared", v, 32'h1002); end
    end
    rd(O_SEED, v); chk("R3 R6 poly32a check string", v, 32'h0376E6E7);
    wr(O_CTRL, 32'h5001);
    for (int i = 0; i < 9; i++) wr(O_DATA, 32'h31 + i);
    rd(O_SEED, v); chk("R3 poly1021 check string", v, 32'h31C3);
    wr(O_CTRL, 32'h0301);
    rd(O_RSLT, v); chk("R9 R10 result shaping", v, m_out(32'h0301, 32'h31C3));
    wr(O_CTRL, 32'h5000);
    for (int i = 0; i < 9; i++) wr(O_DATA, 32'h31 + i);
    rd(O_SEED, v); chk("R3 poly8005 check string", v, 32'hFEE8);

    // R4: checksum with end-around carry
    wr(O_CTRL, 32'h4008);
    wr(O_DATA, 32'hFFFF_0001);
    rd(O_SEED, v); chk("R4 word sum", v, 32'h0001);
    wr(O_CTRL, 32'h1008);
    wr(O_DATA, 32'h1234_56FF);
    rd(O_SEED, v); chk("R4 byte sum", v, 32'h0100);

    // R12: unassigned kind leaves state
    wr(O_SEED, 32'h1234_ABCD);
    wr(O_CTRL, 32'h0205);
    wr(O_DATA, 32'hDEAD_BEEF);
    rd(O_SEED, v); chk("R12 state kept", v, 32'h1234_ABCD);
    rd(O_RSLT, v); chk("R10 full width invert", v, 32'hEDCB_5432);

    // R13: back-to-back data writes
    wr(O_CTRL, 32'h60B2);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      req_valid = 1; req_write = 1; req_addr = O_DATA; req_wdata = 32'h0102_0304 * (i + 1);
      @(negedge clk);
    end
    req_valid = 0; req_write = 0;
    for (int i = 0; i < 4; i++) begin
      m_state = m_step(m_ctrl, m_state, 32'h0102_0304 * (i + 1));
      m_ctrl[14:13] = 0;
    end
    check_all("R13 R7 R8 burst");

    // Random mix: R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int n = 0; n < 250; n++) begin
      logic [31:0] c;
      c = $urandom & 32'h73B0;
      c[3:0] = kinds[$urandom_range(5, 0)];
      if ($urandom_range(3, 0) == 0) wr(O_SEED, $urandom);
      wr(O_CTRL, c);
      for (int j = 0; j < $urandom_range(4, 1); j++) wr(O_DATA, $urandom);
      check_all("R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule